// File: doc/BRIEF.md
# PS/2 Port Register Front End

This block is the processor-facing register set for a single PS/2 keyboard or mouse port. It sits on a 32-bit APB-style peripheral bus and decodes a 4 KB window. The window holds a control word, a clock-divisor word, a data port, a status word, an interrupt-status word and a fixed block of identification bytes. The line serialiser and the device-side byte queue sit outside the block. The block reaches received bytes through a valid/ready handshake, and it hands bytes for transmission out as a one-cycle strobe.

Software polls the status word or waits for the single level interrupt. It then reads the data port to pull the next received byte. A read of the data port advances the device queue only when a byte is waiting. An idle read returns the last byte again. The parity flag in the status word is always derived from the byte currently held, so it tracks whatever the last data read produced. The transmit side never reports back-pressure: it always reads as empty.

Read data is registered. It is captured on the setup-phase clock edge and presented throughout the access phase, with PREADY tied high. Writes take effect on the access-phase edge.

Top module: `ps2p_port_regs`

## Requirements
- R1: A synchronous active-high reset clears control, divisor and held-byte registers to 0. It also clears read data, the transmit strobe and the interrupt output to 0.
- R2: Control (byte offset 0x000) and divisor (byte offset 0x00C) store the full 32-bit written value and read it back unchanged.
- R3: The status word (offset 0x004) has bit 6 always 1 (transmit empty) and bit 4 equal to the pending flag. Bit 2 is the XOR of the eight bits of the held byte. All other bits are 0.
- R4: A data read (offset 0x008) while a byte is pending drives rx_ready high for exactly the setup-phase cycle. It loads the offered byte into the held register and returns that byte in bits 7:0, with the upper bits 0.
- R5: A data read while nothing is pending leaves rx_ready low and returns the held byte unchanged.
- R6: A write to offset 0x008 raises tx_stb for exactly one cycle after the access edge, with tx_byte equal to bits 7:0 of the written word.
- R7: The interrupt output is registered and equals (pending AND control bit 4) OR control bit 3. A control write is reflected in the same edge that stores the new control value.
- R8: The interrupt-status word (offset 0x010) has bit 0 equal to the pending flag and bit 1 always 1. All other bits are 0.
- R9: Offsets 0xFE0 to 0xFFC, one byte per word, read in turn as 0x50, 0x10, 0x04, 0x00, 0x0D, 0xF0, 0x05, 0xB1.
- R10: A read of any other offset, or of any offset with address bits 1:0 nonzero, returns 0. A write to status, interrupt status, identification or unmapped offsets changes no register and raises no transmit strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| psel | input | 1 | Bus select |
| penable | input | 1 | Bus access phase |
| pwrite | input | 1 | Bus write when 1 |
| paddr | input | 12 | Byte address within the window |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Registered read data, valid in the access phase |
| pready | output | 1 | Always 1 |
| rx_valid | input | 1 | Device side offers a received byte (pending flag) |
| rx_byte | input | 8 | Offered received byte |
| rx_ready | output | 1 | Byte taken this cycle |
| tx_stb | output | 1 | One-cycle transmit request |
| tx_byte | output | 8 | Byte to transmit |
| irq | output | 1 | Level interrupt |

## Verification
The hardest situation to reach from the ports is a data read that consumes one byte while a second byte is already queued behind it. Here the pending flag must stay high, the held byte must change, and the parity and interrupt must follow the new byte rather than the old one. The bench's device model is a small queue, so the stimulus preloads two bytes before reading. It then checks status and interrupt status between the reads. The interrupt enable is switched on only after the last byte has arrived, so that consuming that byte must drop the interrupt on the following edge.

// File: rtl/ps2p_pkg.sv
package ps2p_pkg;

  typedef enum logic [2:0] {
    SEL_CTRL,
    SEL_STAT,
    SEL_DATA,
    SEL_DIV,
    SEL_INTS,
    SEL_ID,
    SEL_NONE
  } ps2p_sel_e;

  // bit positions that software decodes
  localparam int ST_TX_EMPTY = 6;
  localparam int ST_RX_FULL  = 4;
  localparam int ST_RX_PAR   = 2;
  localparam int CT_RX_IE    = 4;
  localparam int CT_FORCE    = 3;
  localparam int IS_RX       = 0;
  localparam int IS_TX       = 1;

  localparam int ID_BYTES    = 8;

  function automatic logic [7:0] id_byte(input logic [2:0] idx);
    logic [7:0] b;
    case (idx)
      3'd0: b = 8'h50;
      3'd1: b = 8'h10;
      3'd2: b = 8'h04;
      3'd3: b = 8'h00;
      3'd4: b = 8'h0D;
      3'd5: b = 8'hF0;
      3'd6: b = 8'h05;
      default: b = 8'hB1;
    endcase
    return b;
  endfunction

endpackage

// File: rtl/ps2p_decode.sv
module ps2p_decode
  import ps2p_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic [ADDR_W-1:0] addr,
  output ps2p_sel_e         sel,
  output logic [2:0]        id_idx
);
  localparam int WORD_W  = ADDR_W - 2;
  localparam int ID_BASE = (1 << ADDR_W) - 4 * ID_BYTES;

  logic [WORD_W-1:0] word;
  logic              aligned;
  logic              in_id;

  assign word    = addr[ADDR_W-1:2];
  assign aligned = (addr[1:0] == 2'b00);
  assign in_id   = (addr >= ADDR_W'(ID_BASE));
  assign id_idx  = addr[4:2];

  always_comb begin
    sel = SEL_NONE;
    if (aligned) begin
      if (in_id)                     sel = SEL_ID;
      else if (word == WORD_W'(0))   sel = SEL_CTRL;
      else if (word == WORD_W'(1))   sel = SEL_STAT;
      else if (word == WORD_W'(2))   sel = SEL_DATA;
      else if (word == WORD_W'(3))   sel = SEL_DIV;
      else if (word == WORD_W'(4))   sel = SEL_INTS;
    end
  end

endmodule

// File: rtl/ps2p_regs.sv
module ps2p_regs
  import ps2p_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_setup,
  input  ps2p_sel_e         sel,
  input  logic [DATA_W-1:0] wdata,
  input  logic              rx_valid,
  input  logic [BYTE_W-1:0] rx_byte,
  output logic              rx_ready,
  output logic [DATA_W-1:0] ctrl_q,
  output logic [DATA_W-1:0] ctrl_nx,
  output logic [DATA_W-1:0] div_q,
  output logic [BYTE_W-1:0] held_q,
  output logic              tx_stb,
  output logic [BYTE_W-1:0] tx_byte
);
  logic wr_ctrl, wr_div, wr_data;

  assign wr_ctrl  = wr_en && (sel == SEL_CTRL);
  assign wr_div   = wr_en && (sel == SEL_DIV);
  assign wr_data  = wr_en && (sel == SEL_DATA);
  assign rx_ready = rd_setup && (sel == SEL_DATA) && rx_valid;
  assign ctrl_nx  = wr_ctrl ? wdata : ctrl_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q  <= '0;
      div_q   <= '0;
      held_q  <= '0;
      tx_stb  <= 1'b0;
      tx_byte <= '0;
    end else begin
      ctrl_q <= ctrl_nx;
      if (wr_div)   div_q  <= wdata;
      if (rx_ready) held_q <= rx_byte;
      tx_stb <= wr_data;
      if (wr_data)  tx_byte <= wdata[BYTE_W-1:0];
    end
  end

  a_r4_ready_needs_valid: assert property (@(posedge clk) disable iff (rst)
    rx_ready |-> rx_valid);
  a_r4_consume_loads: assert property (@(posedge clk) disable iff (rst)
    rx_ready |=> held_q == $past(rx_byte));
  a_r5_held_stable: assert property (@(posedge clk) disable iff (rst)
    !rx_ready |=> $stable(held_q));
  a_r6_tx_from_write: assert property (@(posedge clk) disable iff (rst)
    tx_stb |-> $past(wr_en && sel == SEL_DATA));
  a_r10_div_untouched: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && sel == SEL_DIV) |=> $stable(div_q));

endmodule

// File: rtl/ps2p_irq.sv
module ps2p_irq (
  input  logic clk,
  input  logic rst,
  input  logic pending,
  input  logic rx_ie_nx,
  input  logic force_nx,
  output logic irq
);
  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= (pending && rx_ie_nx) || force_nx;
  end

  a_r7_force_wins: assert property (@(posedge clk) disable iff (rst)
    force_nx |=> irq);
  a_r7_quiet: assert property (@(posedge clk) disable iff (rst)
    (!pending && !force_nx) |=> !irq);

endmodule

// File: rtl/ps2p_rdmux.sv
module ps2p_rdmux
  import ps2p_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  ps2p_sel_e         sel,
  input  logic [2:0]        id_idx,
  input  logic [DATA_W-1:0] ctrl_q,
  input  logic [DATA_W-1:0] div_q,
  input  logic [BYTE_W-1:0] held_q,
  input  logic              pending,
  input  logic              consume,
  input  logic [BYTE_W-1:0] rx_byte,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] word;
  logic [BYTE_W-1:0] data_now;

  assign data_now = consume ? rx_byte : held_q;

  always_comb begin
    word = '0;
    case (sel)
      SEL_CTRL: word = ctrl_q;
      SEL_DIV:  word = div_q;
      SEL_DATA: word[BYTE_W-1:0] = data_now;
      SEL_STAT: begin
        word[ST_TX_EMPTY] = 1'b1;
        word[ST_RX_FULL]  = pending;
        word[ST_RX_PAR]   = ^held_q;
      end
      SEL_INTS: begin
        word[IS_RX] = pending;
        word[IS_TX] = 1'b1;
      end
      SEL_ID:   word[7:0] = id_byte(id_idx);
      default:  word = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)       rdata <= '0;
    else if (load) rdata <= word;
  end

  a_r3_tx_empty: assert property (@(posedge clk) disable iff (rst)
    (load && sel == SEL_STAT) |=> rdata[ST_TX_EMPTY]);
  a_r8_tx_flag: assert property (@(posedge clk) disable iff (rst)
    (load && sel == SEL_INTS) |=> rdata[IS_TX]);
  a_r10_unmapped_zero: assert property (@(posedge clk) disable iff (rst)
    (load && sel == SEL_NONE) |=> rdata == '0);
  a_r4_upper_zero: assert property (@(posedge clk) disable iff (rst)
    (load && sel == SEL_DATA) |=> rdata[DATA_W-1:BYTE_W] == '0);

endmodule

// File: rtl/ps2p_port_regs.sv
module ps2p_port_regs
  import ps2p_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [DATA_W-1:0] pwdata,
  output logic [DATA_W-1:0] prdata,
  output logic              pready,
  input  logic              rx_valid,
  input  logic [BYTE_W-1:0] rx_byte,
  output logic              rx_ready,
  output logic              tx_stb,
  output logic [BYTE_W-1:0] tx_byte,
  output logic              irq
);
  ps2p_sel_e         sel;
  logic [2:0]        id_idx;
  logic              wr_en, rd_setup;
  logic [DATA_W-1:0] ctrl_q, ctrl_nx, div_q;
  logic [BYTE_W-1:0] held_q;

  assign pready   = 1'b1;
  assign wr_en    = psel && penable && pwrite;
  assign rd_setup = psel && !penable && !pwrite;

  ps2p_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr   (paddr),
    .sel    (sel),
    .id_idx (id_idx)
  );

  ps2p_regs #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_regs (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .rd_setup (rd_setup),
    .sel      (sel),
    .wdata    (pwdata),
    .rx_valid (rx_valid),
    .rx_byte  (rx_byte),
    .rx_ready (rx_ready),
    .ctrl_q   (ctrl_q),
    .ctrl_nx  (ctrl_nx),
    .div_q    (div_q),
    .held_q   (held_q),
    .tx_stb   (tx_stb),
    .tx_byte  (tx_byte)
  );

  ps2p_irq u_irq (
    .clk      (clk),
    .rst      (rst),
    .pending  (rx_valid),
    .rx_ie_nx (ctrl_nx[CT_RX_IE]),
    .force_nx (ctrl_nx[CT_FORCE]),
    .irq      (irq)
  );

  ps2p_rdmux #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_rd (
    .clk     (clk),
    .rst     (rst),
    .load    (rd_setup),
    .sel     (sel),
    .id_idx  (id_idx),
    .ctrl_q  (ctrl_q),
    .div_q   (div_q),
    .held_q  (held_q),
    .pending (rx_valid),
    .consume (rx_ready),
    .rx_byte (rx_byte),
    .rdata   (prdata)
  );

  a_r7_irq_level: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> irq == (($past(rx_valid) && ctrl_q[CT_RX_IE]) || ctrl_q[CT_FORCE]));
  a_r6_single_strobe: assert property (@(posedge clk) disable iff (rst)
    (tx_stb && !$past(wr_en)) |-> 1'b0);

endmodule

// File: tb/ps2p_port_regs_tb.sv
module ps2p_port_regs_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [11:0] paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata;
  logic        pready;
  logic        rx_valid;
  logic [7:0]  rx_byte;
  logic        rx_ready;
  logic        tx_stb;
  logic [7:0]  tx_byte;
  logic        irq;

  always #2 clk = ~clk;

  ps2p_port_regs dut_i (
    .clk(clk), .rst(rst), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pready(pready),
    .rx_valid(rx_valid), .rx_byte(rx_byte), .rx_ready(rx_ready),
    .tx_stb(tx_stb), .tx_byte(tx_byte), .irq(irq)
  );

  // device-side queue model
  logic [7:0] q [0:15];
  logic [3:0] wr_ptr = '0;
  logic [3:0] rd_ptr = '0;
  assign rx_valid = (wr_ptr != rd_ptr);
  assign rx_byte  = q[rd_ptr];
  always @(posedge clk) if (rx_valid && rx_ready) rd_ptr <= rd_ptr + 4'd1;

  int tx_count = 0;
  logic [7:0] tx_last = '0;
  always @(posedge clk) if (tx_stb) begin
    tx_count <= tx_count + 1;
    tx_last  <= tx_byte;
  end

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic push(input logic [7:0] b);
    @(negedge clk);
    q[wr_ptr] = b;
    wr_ptr = wr_ptr + 4'd1;
  endtask

  task automatic bus_read(input logic [11:0] a, output logic [31:0] d, output logic rdy);
    @(negedge clk);
    psel = 1'b1; penable = 1'b0; pwrite = 1'b0; paddr = a;
    #1 rdy = rx_ready;
    @(negedge clk);
    penable = 1'b1;
    #1 d = prdata;
    @(negedge clk);
    psel = 1'b0; penable = 1'b0;
  endtask

  task automatic bus_write(input logic [11:0] a, input logic [31:0] w);
    @(negedge clk);
    psel = 1'b1; penable = 1'b0; pwrite = 1'b1; paddr = a; pwdata = w;
    @(negedge clk);
    penable = 1'b1;
    @(negedge clk);
    psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
  endtask

  typedef struct packed {
    logic        wr;
    logic [11:0] addr;
    logic [31:0] wdata;
    logic [31:0] exp;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 21;
  // R2 R3 R8 R9 R10 register-map vectors, no byte pending
  localparam vec_t VEC [0:NV-1] = '{
    '{1'b1, 12'h000, 32'hA5A5_0004, 32'h0, 4'd2},
    '{1'b0, 12'h000, 32'h0, 32'hA5A5_0004, 4'd2},
    '{1'b1, 12'h00C, 32'hDEAD_00FF, 32'h0, 4'd2},
    '{1'b0, 12'h00C, 32'h0, 32'hDEAD_00FF, 4'd2},
    '{1'b0, 12'h004, 32'h0, 32'h0000_0040, 4'd3},
    '{1'b0, 12'h010, 32'h0, 32'h0000_0002, 4'd8},
    '{1'b0, 12'hFE0, 32'h0, 32'h50, 4'd9},
    '{1'b0, 12'hFE4, 32'h0, 32'h10, 4'd9},
    '{1'b0, 12'hFE8, 32'h0, 32'h04, 4'd9},
    '{1'b0, 12'hFEC, 32'h0, 32'h00, 4'd9},
    '{1'b0, 12'hFF0, 32'h0, 32'h0D, 4'd9},
    '{1'b0, 12'hFF4, 32'h0, 32'hF0, 4'd9},
    '{1'b0, 12'hFF8, 32'h0, 32'h05, 4'd9},
    '{1'b0, 12'hFFC, 32'h0, 32'hB1, 4'd9},
    '{1'b0, 12'h014, 32'h0, 32'h0, 4'd10},
    '{1'b0, 12'h800, 32'h0, 32'h0, 4'd10},
    '{1'b0, 12'h001, 32'h0, 32'h0, 4'd10},
    '{1'b1, 12'h004, 32'h0000_FFFF, 32'h0, 4'd10},
    '{1'b1, 12'h010, 32'h0000_0001, 32'h0, 4'd10},
    '{1'b1, 12'hFE0, 32'h0000_0077, 32'h0, 4'd10},
    '{1'b0, 12'h000, 32'h0, 32'hA5A5_0004, 4'd10}
  };

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic rdy;
    int t0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check("R1 irq", {31'b0, irq}, 32'h0);
    check("R1 tx_stb", {31'b0, tx_stb}, 32'h0);
    check("R1 prdata", prdata, 32'h0);
    bus_read(12'h000, d, rdy); check("R1 ctrl", d, 32'h0);
    bus_read(12'h00C, d, rdy); check("R1 div", d, 32'h0);
    bus_read(12'h008, d, rdy); check("R1/R5 data", d, 32'h0);
    check("R5 no ready", {31'b0, rdy}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i].wr) begin
        t0 = tx_count;
        bus_write(VEC[i].addr, VEC[i].wdata);
        @(negedge clk);
        if (VEC[i].req == 4'd10)
          check($sformatf("R10 no strobe vec%0d", i), tx_count, t0);
      end else begin
        bus_read(VEC[i].addr, d, rdy);
        check($sformatf("R%0d vec%0d", VEC[i].req, i), d, VEC[i].exp);
      end
    end

    // R3 R4 R5 R8 receive path
    bus_write(12'h000, 32'h0);
    push(8'h07);
    bus_read(12'h004, d, rdy); check("R3 status pending", d, 32'h50);
    bus_read(12'h010, d, rdy); check("R8 int pending", d, 32'h3);
    bus_read(12'h008, d, rdy); check("R4 data", d, 32'h07);
    check("R4 ready", {31'b0, rdy}, 32'h1);
    bus_read(12'h004, d, rdy); check("R3 parity odd", d, 32'h44);
    bus_read(12'h008, d, rdy); check("R5 data again", d, 32'h07);
    check("R5 ready low", {31'b0, rdy}, 32'h0);

    // two queued bytes
    push(8'h3C);
    push(8'h81);
    bus_read(12'h008, d, rdy); check("R4 first of two", d, 32'h3C);
    bus_read(12'h004, d, rdy); check("R3 still full, even", d, 32'h50);
    bus_read(12'h010, d, rdy); check("R8 still pending", d, 32'h3);

    // R7 interrupt
    bus_write(12'h000, 32'h10);
    check("R7 enable with pending", {31'b0, irq}, 32'h1);
    bus_read(12'h008, d, rdy); check("R4 second byte", d, 32'h81);
    check("R7 drop after consume", {31'b0, irq}, 32'h0);
    bus_read(12'h004, d, rdy); check("R3 empty, parity even", d, 32'h40);
    bus_write(12'h000, 32'h08);
    check("R7 force", {31'b0, irq}, 32'h1);
    bus_write(12'h000, 32'h0);
    check("R7 clear", {31'b0, irq}, 32'h0);

    // R6 transmit
    t0 = tx_count;
    bus_write(12'h008, 32'h1234_56C3);
    @(negedge clk);
    @(negedge clk);
    check("R6 one strobe", tx_count, t0 + 1);
    check("R6 byte", {24'b0, tx_last}, 32'hC3);

    // R1 reset mid-run
    bus_write(12'h000, 32'h0000_0018);
    bus_write(12'h00C, 32'h55);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); @(negedge clk); rst = 1'b0;
    check("R1 irq after reset", {31'b0, irq}, 32'h0);
    bus_read(12'h000, d, rdy); check("R1 ctrl after reset", d, 32'h0);
    bus_read(12'h00C, d, rdy); check("R1 div after reset", d, 32'h0);
    bus_read(12'h008, d, rdy); check("R1 held after reset", d, 32'h0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule